// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Deadtime Generator

This block turns two logic commands into the two gate signals of a half-bridge power stage. The high-side command is active high and the low-side command is active low. When the two commands agree (both low or both high) exactly one gate is selected. When they ask for both switches at once, or for neither, both gates stay off. Because the low-side command is inverted, a single PWM signal wired to both command pins gives complementary drive with the deadtime added automatically. A request that would overlap the other switch is refused outright.

Both commands pass through two-flop synchronisers before they are decoded. The gate outputs are registered. Each gate owns a timer that counts the cycles since that gate last switched off. The opposite gate may only switch on once that count reaches the programmed deadtime, so both transition directions see the same gap. An enable from the fault path gates both outputs directly, without synchroniser latency. A one-cycle status pulse marks every new shoot-through request.

Top module: `hb_half_bridge`

## Requirements
- R1: While reset is asserted and on the first cycles after it, both gate outputs and the overlap pulse are low.
- R2: When the enable input is low at a rising edge, both gate outputs are low after that edge, whatever the commands are.
- R3: With the high-side command at 0 and the low-side command at 1, no gate is requested and both outputs remain low.
- R4: With both commands at 0, only the low-side gate is driven high.
- R5: With both commands at 1, only the high-side gate is driven high.
- R6: With the high-side command at 1 and the low-side command at 0, the interlock forces both gates low.
- R7: The two gate outputs are never high in the same cycle.
- R8: When a gate falls at rising edge E, the other gate cannot rise before edge E+D, where D is the effective deadtime. A request that arrives earlier is held and takes effect at edge E+D.
- R9: A request that arrives after the deadtime has already run out is followed with no added delay.
- R10: The deadtime is the same number of cycles for a low-to-high handover as for a high-to-low handover.
- R11: The deadtime input is a 10-bit cycle count. The values 0 and 1 are treated as 2.
- R12: The overlap pulse is high for exactly one cycle when a shoot-through request first appears. It is aligned with the edge at which the gates respond to that request, and it does not repeat while the request is held.
- R13: A command change made before rising edge n is reflected on the gates after edge n+2: two synchroniser edges, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_hi | input | 1 | High-side command, active high, asynchronous |
| cmd_lo_n | input | 1 | Low-side command, active low, asynchronous |
| drive_en | input | 1 | Enable from the fault path; low forces both gates off |
| dead_cycles | input | 10 | Deadtime in clock cycles (values below 2 act as 2) |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| overlap_pulse | output | 1 | One-cycle flag on each new shoot-through request |

## Verification
The bench toggles a single complementary signal on both commands at several deadtime settings, including 0 and 1. A design that clamped wrongly, or counted the gap from the wrong edge, would show an off-by-one gap in one direction only. Requests placed inside the deadtime window must be delayed to the exact end of the window, while requests placed well outside it must pass with the bare three-edge latency; a timer that restarts on the wrong event would either delay the late case or release the early case too soon. Short and held overlap bursts check that the interlock blanks both gates and that the status flag fires once per onset rather than staying high. Dropping the enable while a gate is on checks that shutdown needs no synchroniser delay and that the deadtime still guards the next turn-on.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_LO   = 2'd1,
    REQ_HI   = 2'd2,
    REQ_BOTH = 2'd3
  } req_e;

  // Active-high high-side command, active-low low-side command.
  function automatic req_e hb_decode(input logic hi, input logic lo_n);
    case ({hi, lo_n})
      2'b01:   return REQ_NONE;
      2'b00:   return REQ_LO;
      2'b11:   return REQ_HI;
      default: return REQ_BOTH;
    endcase
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      assign d = din;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int CNT_W    = 10,
  parameter int MIN_DEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_now,
  input  logic             gate_next,
  input  logic [CNT_W-1:0] dead_cfg,
  output logic             ready
);

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DEAD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] SAT   = '1;

  function automatic logic [CNT_W-1:0] eff_dead(input logic [CNT_W-1:0] v);
    return (v < MIN_V) ? MIN_V : v;
  endfunction

  logic [CNT_W-1:0] elapsed;
  logic             fall_now;

  assign fall_now = gate_now & ~gate_next;

  // Counts cycles since this gate switched off, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n)             elapsed <= SAT;
    else if (fall_now)      elapsed <= ONE;
    else if (elapsed != SAT) elapsed <= elapsed + ONE;
  end

  assign ready = (elapsed >= eff_dead(dead_cfg));

endmodule

// File: rtl/hb_half_bridge.sv
module hb_half_bridge #(
  parameter int DEAD_W   = 10,
  parameter int SYNC_LEN = 2,
  parameter int MIN_DEAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hi,
  input  logic              cmd_lo_n,
  input  logic              drive_en,
  input  logic [DEAD_W-1:0] dead_cycles,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              overlap_pulse
);
  import hb_pkg::*;

  localparam int GATES = 2;   // index 1 = high side, index 0 = low side

  logic [1:0]       cmd_sync;
  req_e             req;
  logic [GATES-1:0] want;
  logic [GATES-1:0] gate_q;
  logic [GATES-1:0] gate_d;
  logic [GATES-1:0] off_ready;
  logic             overlap_now;
  logic             overlap_q;
  logic             pulse_q;

  // Reset value is the "no request" pattern: high cmd 0, low cmd_n 1.
  hb_sync #(
    .W      (2),
    .STAGES (SYNC_LEN),
    .RST_VAL(2'b01)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cmd_hi, cmd_lo_n}),
    .dout (cmd_sync)
  );

  assign req         = hb_decode(cmd_sync[1], cmd_sync[0]);
  assign want[1]     = (req == REQ_HI);
  assign want[0]     = (req == REQ_LO);
  assign overlap_now = (req == REQ_BOTH);

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    localparam int PEER = GATES - 1 - g;

    assign gate_d[g] = drive_en & want[g] & ~gate_q[PEER] & off_ready[PEER];

    hb_dead_timer #(
      .CNT_W   (DEAD_W),
      .MIN_DEAD(MIN_DEAD)
    ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_now (gate_q[g]),
      .gate_next(gate_d[g]),
      .dead_cfg (dead_cycles),
      .ready    (off_ready[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) gate_q[g] <= 1'b0;
      else        gate_q[g] <= gate_d[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overlap_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      overlap_q <= overlap_now;
      pulse_q   <= overlap_now & ~overlap_q;
    end
  end

  assign gate_hi       = gate_q[1];
  assign gate_lo       = gate_q[0];
  assign overlap_pulse = pulse_q;

endmodule

// File: rtl/hb_half_bridge_chk.sv
module hb_half_bridge_chk #(
  parameter int DEAD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_en,
  input logic [DEAD_W-1:0] dead_cycles,
  input logic              gate_hi,
  input logic              gate_lo,
  input logic              overlap_pulse,
  input logic              overlap_now
);

  localparam int CW = DEAD_W + 1;

  logic [CW-1:0] since_hi_off;
  logic [CW-1:0] since_lo_off;
  logic [CW-1:0] need;

  assign need = (dead_cycles < DEAD_W'(2)) ? CW'(2) : {1'b0, dead_cycles};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_hi_off <= '1;
      since_lo_off <= '1;
    end else begin
      if (gate_hi)                  since_hi_off <= '0;
      else if (since_hi_off != '1)  since_hi_off <= since_hi_off + CW'(1);
      if (gate_lo)                  since_lo_off <= '0;
      else if (since_lo_off != '1)  since_lo_off <= since_lo_off + CW'(1);
    end
  end

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R7

  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> (!gate_hi && !gate_lo)); // R2

  AST_OVERLAP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_pulse |-> (!gate_hi && !gate_lo)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_pulse |=> !overlap_pulse); // R12

  AST_PULSE_ON_ONSET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overlap_now) |=> overlap_pulse); // R12

  AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (since_lo_off >= need)); // R8

  AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (since_hi_off >= need)); // R10

endmodule

bind hb_half_bridge hb_half_bridge_chk #(.DEAD_W(DEAD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .drive_en     (drive_en),
  .dead_cycles  (dead_cycles),
  .gate_hi      (gate_hi),
  .gate_lo      (gate_lo),
  .overlap_pulse(overlap_pulse),
  .overlap_now  (overlap_now)
);

// File: tb/test_hb_half_bridge.sv
module test_hb_half_bridge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_hi = 1'b0;
  logic       cmd_lo_n = 1'b1;
  logic       drive_en = 1'b0;
  logic [9:0] dead_cycles = 10'd4;
  logic       gate_hi, gate_lo, overlap_pulse;

  always #10 clk = ~clk;  // 50 MHz

  hb_half_bridge i_hb_half_bridge (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_hi       (cmd_hi),
    .cmd_lo_n     (cmd_lo_n),
    .drive_en     (drive_en),
    .dead_cycles  (dead_cycles),
    .gate_hi      (gate_hi),
    .gate_lo      (gate_lo),
    .overlap_pulse(overlap_pulse)
  );

  typedef struct {
    bit    hi;
    bit    lo;
    bit    pl;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // Reference state: edge number, time of each gate's last fall.
  int edge_no = 0;
  int off_hi_at = -100000;
  int off_lo_at = -100000;
  bit p_hi = 0, p_lo = 0, p_ov = 0;
  bit h1_hi = 0, h1_ln = 1, h2_hi = 0, h2_ln = 1;

  // Driver: drives one cycle of stimulus and predicts the next edge.
  task automatic apply(input bit h, input bit ln, input bit e, input string tag);
    exp_t x;
    int   d;
    bit   gh, gl, ov;
    cmd_hi   = h;
    cmd_lo_n = ln;
    drive_en = e;
    edge_no++;
    d  = (int'(dead_cycles) < 2) ? 2 : int'(dead_cycles);
    gh = e && h2_hi && h2_ln && !p_lo && ((edge_no - off_lo_at) >= d);
    gl = e && !h2_hi && !h2_ln && !p_hi && ((edge_no - off_hi_at) >= d);
    ov = h2_hi && !h2_ln;
    x.hi = gh; x.lo = gl; x.pl = ov && !p_ov; x.tag = tag;
    if (p_hi && !gh) off_hi_at = edge_no;
    if (p_lo && !gl) off_lo_at = edge_no;
    p_hi = gh; p_lo = gl; p_ov = ov;
    h2_hi = h1_hi; h2_ln = h1_ln;
    h1_hi = h;     h1_ln = ln;
    sb.push_back(x);
    @(negedge clk);
  endtask

  task automatic hold(input bit h, input bit ln, input bit e, input int n, input string tag);
    for (int i = 0; i < n; i++) apply(h, ln, e, tag);
  endtask

  // Monitor: pops one prediction per edge and compares.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      checks++;
      if (gate_hi !== x.hi || gate_lo !== x.lo || overlap_pulse !== x.pl) begin
        fails++;
        $display("FAIL %s: hi/lo/pulse = %b%b%b expected %b%b%b (edge %0d)",
                 x.tag, gate_hi, gate_lo, overlap_pulse, x.hi, x.lo, x.pl, edge_no);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cmd_hi = 1'b1; cmd_lo_n = 1'b1; drive_en = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (gate_hi !== 1'b0 || gate_lo !== 1'b0 || overlap_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs %b%b%b expected 000", gate_hi, gate_lo, overlap_pulse);
    end
    rst_n = 1'b1;

    // Truth table, deadtime 4
    dead_cycles = 10'd4;
    hold(0, 1, 1, 6,  "R1/R3 neither");
    hold(0, 0, 1, 10, "R4/R13 low only");
    hold(0, 1, 1, 8,  "R3 neither");
    hold(1, 1, 1, 10, "R5 high only");
    hold(1, 0, 1, 8,  "R6/R12 overlap held");
    hold(1, 1, 1, 10, "R5 after overlap");
    hold(1, 1, 0, 6,  "R2 enable low");
    hold(1, 1, 1, 10, "R2 enable back");
    for (int i = 0; i < 4; i++) begin
      hold(1, 1, 0, 2, "R2 chop off");
      hold(1, 1, 1, 7, "R2 chop on");
    end

    // Complementary drive on one signal, several deadtimes
    dead_cycles = 10'd5;
    for (int i = 0; i < 4; i++) begin
      hold(1, 1, 1, 12, "R8/R10 compl high");
      hold(0, 0, 1, 12, "R8/R10 compl low");
    end
    dead_cycles = 10'd0;
    for (int i = 0; i < 3; i++) begin
      hold(1, 1, 1, 7, "R11 clamp0 high");
      hold(0, 0, 1, 7, "R11 clamp0 low");
    end
    dead_cycles = 10'd1;
    for (int i = 0; i < 3; i++) begin
      hold(1, 1, 1, 7, "R11 clamp1 high");
      hold(0, 0, 1, 7, "R11 clamp1 low");
    end
    dead_cycles = 10'd2;
    for (int i = 0; i < 10; i++) begin
      apply(1, 1, 1, "R7 fast toggle");
      apply(0, 0, 1, "R7 fast toggle");
    end
    hold(0, 1, 1, 6, "R3 settle");

    // Request inside the window waits
    dead_cycles = 10'd8;
    hold(0, 0, 1, 14, "R8 low on");
    hold(0, 1, 1, 2,  "R8 short gap");
    hold(1, 1, 1, 16, "R8 high waits");
    hold(0, 1, 1, 3,  "R8 short gap");
    hold(0, 0, 1, 16, "R8 low waits");

    // Request outside the window follows directly
    dead_cycles = 10'd3;
    hold(0, 1, 1, 8,  "R9 long gap");
    hold(1, 1, 1, 10, "R9 high direct");
    hold(0, 1, 1, 8,  "R9 long gap");
    hold(0, 0, 1, 10, "R9 low direct");

    // Overlap bursts
    hold(1, 1, 1, 8, "R12 base high");
    for (int n = 1; n <= 3; n++) begin
      hold(1, 0, 1, n, "R12/R6 overlap burst");
      hold(1, 1, 1, 8, "R12 recover high");
    end
    hold(1, 0, 1, 5, "R12 overlap hold");
    hold(0, 1, 1, 6, "R3 settle");

    // Long deadtime
    dead_cycles = 10'd40;
    for (int i = 0; i < 2; i++) begin
      hold(0, 0, 1, 60, "R10 long low");
      hold(1, 1, 1, 60, "R10 long high");
    end
    hold(0, 1, 1, 4, "R3 final");

    @(posedge clk); @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule